// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the 8-bit status word of a small 8-bit processor. Each time the ALU completes an operation it records three condition flags: zero, digit carry (carry out of the low nibble) and carry. Addition, subtraction and rotate-through-carry each set these flags in their own way. Subtraction is formed as an addition of the two's complement of the second operand, so after a subtract the carry and digit-carry bits mean "no borrow" rather than "borrow".

The same word holds two reset-cause bits, a time-out bit and a power-down bit. Software cannot write them. Only the power-up, sleep, watchdog-clear and watchdog-expiry strobes change them. Software may write the word like any other location. When the instruction that writes it also produces flags, the hardware flags win over the written data. Instruction decode, the watchdog counter and the rest of the datapath sit outside this block.

Top module: `alu_status_reg`

## Requirements
- R1: While the power-on reset `rst_n` is low, and on the first sample after it, `status_o` is 0x18: time-out = 1, power-down = 1, and zero, digit carry and carry are all 0.
- R2: Bits 7..5 of `status_o` always read 0, even after software writes 1s to them. Bit 4 is time-out, bit 3 is power-down, bit 2 is zero, bit 1 is digit carry and bit 0 is carry.
- R3: An operation that affects zero sets bit 2 when its 8-bit result is 0 and clears it otherwise. Add, subtract (a - b), AND, OR and XOR all affect zero.
- R4: Add (`op_i` = 0) sets carry to the carry out of bit 7 of a + b, and sets digit carry to the carry out of bit 3.
- R5: Subtract (`op_i` = 1) computes a - b. Carry is 1 exactly when a >= b (unsigned), and digit carry is 1 exactly when a[3:0] >= b[3:0].
- R6: Rotate right (`op_i` = 5) loads carry with a[0], and rotate left (`op_i` = 6) loads carry with a[7]. Zero and digit carry keep their values.
- R7: A software write (`wr_en_i` with `alu_go_i` low) copies `wr_data_i[2:0]` into zero, digit carry and carry. Time-out and power-down are left unchanged.
- R8: When `alu_go_i` and `wr_en_i` are both high, `wr_data_i` has no effect on bits 2..0. Flags that the operation affects take their hardware values, and the others hold. A clear (`op_i` = 7) sets zero and leaves digit carry and carry unchanged.
- R9: The logic operations AND (`op_i` = 2), OR (3) and XOR (4) affect only zero. Digit carry and carry hold.
- R10: A sleep strobe sets time-out and clears power-down. A watchdog expiry clears time-out and leaves power-down unchanged. A watchdog clear sets both bits. A power-up strobe sets both bits and leaves the three ALU flags unchanged.
- R11: When several event strobes are high in one cycle, the priority is power-up, then watchdog expiry, then watchdog clear, then sleep.
- R12: Every update shows on `status_o` after the rising clock edge that samples the request. In a cycle with no operation, no write and no event, `status_o` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| alu_go_i | input | 1 | ALU operation completes this cycle |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 rotate right, 6 rotate left, 7 clear |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| wr_en_i | input | 1 | Software write to the status word |
| wr_data_i | input | 8 | Write data |
| pwrup_i | input | 1 | Power-up event strobe |
| sleep_i | input | 1 | Sleep event strobe |
| wdt_clr_i | input | 1 | Watchdog-clear event strobe |
| wdt_tmo_i | input | 1 | Watchdog-expiry event strobe |
| status_o | output | 8 | Status word |

## Verification
Each flag, write and event result is due exactly one rising edge after its request. The power-on reset value is due at once, because that reset is asynchronous. The bench drives each request on a falling edge and holds it through one rising edge. It then compares the whole status byte on the next falling edge against a model of the requirements, so a result that arrives early, late or not at all shows up in the same comparison. Cycles with no request come straight after updates and confirm that the word then holds.

// File: rtl/stat_pkg.sv
package stat_pkg;

   localparam int unsigned SR_W   = 8;
   localparam int unsigned BIT_TO = 4;
   localparam int unsigned BIT_PD = 3;
   localparam int unsigned BIT_Z  = 2;
   localparam int unsigned BIT_DC = 1;
   localparam int unsigned BIT_C  = 0;
   localparam int unsigned NFLAG  = 3;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_IOR = 3'd3,
      OP_XOR = 3'd4,
      OP_RRC = 3'd5,
      OP_RLC = 3'd6,
      OP_CLR = 3'd7
   } alu_op_e;

   // bit order matches the low three bits of the status word
   typedef struct packed {
      logic z;
      logic dc;
      logic c;
   } flags_t;

endpackage

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
   import stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NIB_W  = 4,
   parameter bit          ROT_EN = 1'b1
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output flags_t            val_o,
   output flags_t            aff_o
);

   localparam int unsigned FULL_W = DATA_W + 1;
   localparam int unsigned HALF_W = NIB_W + 1;

   if (DATA_W < 2) begin : g_bad_w
      $error("stat_flag_unit: DATA_W must be at least 2");
   end
   if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
      $error("stat_flag_unit: NIB_W must lie in 1..DATA_W-1");
   end

   logic [FULL_W-1:0] add_full, sub_full;
   logic [HALF_W-1:0] add_half, sub_half;
   logic [DATA_W-1:0] res;
   logic              rot_c, rot_aff;

   // subtraction as a plus inverted b plus one: carry out = no borrow
   assign add_full = {1'b0, a_i} + {1'b0, b_i};
   assign sub_full = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
   assign add_half = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]};
   assign sub_half = {1'b0, a_i[NIB_W-1:0]} + {1'b0, ~b_i[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, 1'b1};

   if (ROT_EN) begin : g_rot
      assign rot_c   = (op_i == OP_RRC) ? a_i[0] : a_i[DATA_W-1];
      assign rot_aff = 1'b1;
   end else begin : g_no_rot
      assign rot_c   = 1'b0;
      assign rot_aff = 1'b0;
   end

   always_comb begin
      res   = '0;
      val_o = '0;
      aff_o = '0;
      unique case (op_i)
         OP_ADD: begin
            res      = add_full[DATA_W-1:0];
            val_o.c  = add_full[DATA_W];
            val_o.dc = add_half[NIB_W];
            aff_o    = '1;
         end
         OP_SUB: begin
            res      = sub_full[DATA_W-1:0];
            val_o.c  = sub_full[DATA_W];
            val_o.dc = sub_half[NIB_W];
            aff_o    = '1;
         end
         OP_AND: begin
            res     = a_i & b_i;
            aff_o.z = 1'b1;
         end
         OP_IOR: begin
            res     = a_i | b_i;
            aff_o.z = 1'b1;
         end
         OP_XOR: begin
            res     = a_i ^ b_i;
            aff_o.z = 1'b1;
         end
         OP_RRC, OP_RLC: begin
            val_o.c = rot_c;
            aff_o.c = rot_aff;
         end
         OP_CLR: begin
            res     = '0;
            aff_o.z = 1'b1;
         end
         default: ;
      endcase
      val_o.z = (res == '0);
   end

endmodule

// File: rtl/stat_flag_reg.sv
module stat_flag_reg
   import stat_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   alu_go_i,
   input  flags_t val_i,
   input  flags_t aff_i,
   input  logic   wr_en_i,
   input  flags_t wr_i,
   output flags_t q_o
);

   logic [NFLAG-1:0] val_v, aff_v, wr_v, q_v, nxt_v;
   logic             wr_block;

   assign val_v = val_i;
   assign aff_v = aff_i;
   assign wr_v  = wr_i;

   // a flag-producing operation masks the software write to all three flags
   assign wr_block = alu_go_i && (|aff_v);

   for (genvar k = 0; k < NFLAG; k++) begin : g_bit
      always_comb begin
         if (alu_go_i && aff_v[k])
            nxt_v[k] = val_v[k];
         else if (wr_en_i && !wr_block)
            nxt_v[k] = wr_v[k];
         else
            nxt_v[k] = q_v[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_v <= '0;
      else        q_v <= nxt_v;
   end

   assign q_o = q_v;

endmodule

// File: rtl/stat_evt_unit.sv
module stat_evt_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic pwrup_i,
   input  logic sleep_i,
   input  logic wdt_clr_i,
   input  logic wdt_tmo_i,
   output logic to_o,
   output logic pd_o
);

   logic to_q, pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else if (pwrup_i) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else if (wdt_tmo_i) begin
         to_q <= 1'b0;
      end else if (wdt_clr_i) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else if (sleep_i) begin
         to_q <= 1'b1;
         pd_q <= 1'b0;
      end
   end

   assign to_o = to_q;
   assign pd_o = pd_q;

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NIB_W  = 4,
   parameter bit          ROT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alu_go_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              wr_en_i,
   input  logic [SR_W-1:0]   wr_data_i,
   input  logic              pwrup_i,
   input  logic              sleep_i,
   input  logic              wdt_clr_i,
   input  logic              wdt_tmo_i,
   output logic [SR_W-1:0]   status_o
);

   localparam int unsigned PAD_W = SR_W - BIT_TO - 1;

   flags_t hw_val, hw_aff, wr_fl, fl_q;
   logic   to_q, pd_q;
   logic   unused_hi;

   assign wr_fl     = flags_t'(wr_data_i[NFLAG-1:0]);
   assign unused_hi = ^wr_data_i[SR_W-1:NFLAG];

   stat_flag_unit #(
      .DATA_W (DATA_W),
      .NIB_W  (NIB_W),
      .ROT_EN (ROT_EN)
   ) u_flag_unit (
      .op_i  (alu_op_e'(op_i)),
      .a_i   (a_i),
      .b_i   (b_i),
      .val_o (hw_val),
      .aff_o (hw_aff)
   );

   stat_flag_reg u_flag_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .alu_go_i (alu_go_i),
      .val_i    (hw_val),
      .aff_i    (hw_aff),
      .wr_en_i  (wr_en_i),
      .wr_i     (wr_fl),
      .q_o      (fl_q)
   );

   stat_evt_unit u_evt_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwrup_i   (pwrup_i),
      .sleep_i   (sleep_i),
      .wdt_clr_i (wdt_clr_i),
      .wdt_tmo_i (wdt_tmo_i),
      .to_o      (to_q),
      .pd_o      (pd_q)
   );

   assign status_o = {{PAD_W{1'b0}}, to_q, pd_q, fl_q.z, fl_q.dc, fl_q.c};

endmodule

// File: rtl/stat_chk.sv
module stat_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alu_go_i,
   input logic [2:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic              wr_en_i,
   input logic              pwrup_i,
   input logic              sleep_i,
   input logic              wdt_clr_i,
   input logic              wdt_tmo_i,
   input logic [7:0]        status_o
);

   logic [DATA_W:0] chk_sum;
   logic            no_evt;

   assign chk_sum = {1'b0, a_i} + {1'b0, b_i};
   assign no_evt  = !pwrup_i && !sleep_i && !wdt_clr_i && !wdt_tmo_i;

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7:5] == 3'b000);

   p_add_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_go_i && op_i == 3'd0) |=> status_o[0] == $past(chk_sum[DATA_W]));

   p_sub_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_go_i && op_i == 3'd1) |=> status_o[0] == $past(a_i >= b_i));

   p_rot_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_go_i && op_i == 3'd5) |=> status_o[0] == $past(a_i[0]) && $stable(status_o[2:1]));

   p_write_keeps_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && no_evt) |=> $stable(status_o[4:3]));

   p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_go_i && wr_en_i && op_i == 3'd7) |=> status_o[2:0] == {1'b1, $past(status_o[1:0])});

   p_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !pwrup_i && !wdt_tmo_i && !wdt_clr_i) |=> status_o[4:3] == 2'b10);

   p_pwrup_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwrup_i |=> status_o[4:3] == 2'b11 && $stable(status_o[2:0]) || alu_go_i || wr_en_i);

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_go_i && !wr_en_i && no_evt) |=> $stable(status_o));

endmodule

bind alu_status_reg stat_chk #(.DATA_W(DATA_W)) u_stat_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .alu_go_i  (alu_go_i),
   .op_i      (op_i),
   .a_i       (a_i),
   .b_i       (b_i),
   .wr_en_i   (wr_en_i),
   .pwrup_i   (pwrup_i),
   .sleep_i   (sleep_i),
   .wdt_clr_i (wdt_clr_i),
   .wdt_tmo_i (wdt_tmo_i),
   .status_o  (status_o)
);

// File: tb/alu_status_reg_test.sv
module alu_status_reg_test;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       alu_go_i, wr_en_i, pwrup_i, sleep_i, wdt_clr_i, wdt_tmo_i;
   logic [2:0] op_i;
   logic [7:0] a_i, b_i, wr_data_i, status_o;

   int checks = 0;
   int fails  = 0;
   logic m_to, m_pd, m_z, m_dc, m_c;

   alu_status_reg uut (
      .clk(clk), .rst_n(rst_n), .alu_go_i(alu_go_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .pwrup_i(pwrup_i), .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i),
      .wdt_tmo_i(wdt_tmo_i), .status_o(status_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] model_word();
      return {3'b000, m_to, m_pd, m_z, m_dc, m_c};
   endfunction

   task automatic check(input string tag, input logic [7:0] exp);
      checks++;
      if (status_o !== exp) begin
         fails++;
         $display("FAIL %s: status actual %02h expected %02h", tag, status_o, exp);
      end
   endtask

   task automatic model_por();
      m_to = 1'b1; m_pd = 1'b1; m_z = 1'b0; m_dc = 1'b0; m_c = 1'b0;
   endtask

   // ev = {power-up, watchdog expiry, watchdog clear, sleep}
   task automatic step(input logic go, input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic we, input logic [7:0] wd,
                       input logic [3:0] ev, input string tag);
      logic [8:0] s;
      logic hz, hdc, hc, az, adc, ac;
      @(negedge clk);
      alu_go_i = go; op_i = op; a_i = a; b_i = b; wr_en_i = we; wr_data_i = wd;
      {pwrup_i, wdt_tmo_i, wdt_clr_i, sleep_i} = ev;
      hz = 0; hdc = 0; hc = 0; az = 0; adc = 0; ac = 0;
      s = {1'b0, a} + {1'b0, b};
      case (op)
         3'd0: begin hz = (s[7:0] == 0); hc = s[8];
                     hdc = ((a & 8'h0F) + (b & 8'h0F)) > 15; az = 1; adc = 1; ac = 1; end
         3'd1: begin hz = (a == b); hc = (a >= b); hdc = (a[3:0] >= b[3:0]);
                     az = 1; adc = 1; ac = 1; end
         3'd2: begin hz = ((a & b) == 0); az = 1; end
         3'd3: begin hz = ((a | b) == 0); az = 1; end
         3'd4: begin hz = ((a ^ b) == 0); az = 1; end
         3'd5: begin hc = a[0]; ac = 1; end
         3'd6: begin hc = a[7]; ac = 1; end
         default: begin hz = 1; az = 1; end
      endcase
      if (go) begin
         if (az)  m_z  = hz;
         if (adc) m_dc = hdc;
         if (ac)  m_c  = hc;
      end else if (we) begin
         {m_z, m_dc, m_c} = wd[2:0];
      end
      if (ev[3])      begin m_to = 1; m_pd = 1; end
      else if (ev[2]) m_to = 0;
      else if (ev[1]) begin m_to = 1; m_pd = 1; end
      else if (ev[0]) begin m_to = 1; m_pd = 0; end
      @(negedge clk);
      alu_go_i = 0; wr_en_i = 0; {pwrup_i, wdt_tmo_i, wdt_clr_i, sleep_i} = 4'b0;
      check(tag, model_word());
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      check(tag, model_word());
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run actual hung expected done");
      finish_run();
   end

   initial begin
      rst_n = 0; alu_go_i = 0; op_i = 0; a_i = 0; b_i = 0; wr_en_i = 0;
      wr_data_i = 0; pwrup_i = 0; sleep_i = 0; wdt_clr_i = 0; wdt_tmo_i = 0;
      model_por();
      repeat (3) @(negedge clk);
      check("R1 during reset", 8'h18);
      rst_n = 1;
      idle("R1 after reset");

      // R2 / R7: software writes
      step(0, 0, 0, 0, 1, 8'hFF, 4'b0, "R2 R7 write all ones");
      check("R2 upper bits zero", {3'b000, status_o[4:0]});
      step(0, 0, 0, 0, 1, 8'h00, 4'b0, "R7 write zeros");
      step(0, 0, 0, 0, 1, 8'hE5, 4'b0, "R7 write pattern");
      idle("R12 hold after write");

      // R3 R4 add sweep, R3 R5 subtract sweep
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 3)
            step(1, 3'd0, a[7:0], b[7:0], 0, 0, 4'b0, "R3 R4 add");
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 3)
            step(1, 3'd1, a[7:0], b[7:0], 0, 0, 4'b0, "R3 R5 subtract");

      // R9 logic ops hold DC and C
      step(0, 0, 0, 0, 1, 8'h03, 4'b0, "R7 preset dc c");
      for (int a = 0; a < 256; a++) begin
         step(1, 3'd2, a[7:0], {a[3:0], a[7:4]}, 0, 0, 4'b0, "R9 R3 and");
         step(1, 3'd3, a[7:0], 8'h00, 0, 0, 4'b0, "R9 R3 or");
         step(1, 3'd4, a[7:0], a[7:0] ^ 8'h10, 0, 0, 4'b0, "R9 R3 xor");
      end

      // R6 rotates with Z and DC preset to 1
      step(0, 0, 0, 0, 1, 8'h06, 4'b0, "R7 preset z dc");
      for (int a = 0; a < 256; a++) begin
         step(1, 3'd5, a[7:0], 8'h00, 0, 0, 4'b0, "R6 rotate right");
         step(1, 3'd6, a[7:0], 8'h00, 0, 0, 4'b0, "R6 rotate left");
      end
      idle("R12 hold after rotate");

      // R8 concurrent operation and write
      step(0, 0, 0, 0, 1, 8'h03, 4'b0, "R7 preset dc c");
      step(1, 3'd7, 8'h55, 8'h00, 1, 8'h00, 4'b0, "R8 clear with write");
      step(1, 3'd7, 8'h55, 8'h00, 1, 8'hFF, 4'b0, "R8 clear with write ones");
      step(1, 3'd0, 8'h0F, 8'h01, 1, 8'h00, 4'b0, "R8 add wins over write");
      step(1, 3'd1, 8'h10, 8'h20, 1, 8'hFF, 4'b0, "R8 sub wins over write");
      step(1, 3'd6, 8'h00, 8'h00, 1, 8'h07, 4'b0, "R8 rotate blocks write");

      // R10 R11 event combinations from two starting states
      for (int e = 0; e < 16; e++) begin
         step(0, 0, 0, 0, 0, 0, 4'b0001, "R10 prep sleep");
         step(0, 0, 0, 0, 0, 0, e[3:0], "R10 R11 events from sleep state");
         step(0, 0, 0, 0, 0, 0, 4'b0100, "R10 prep expiry");
         step(0, 0, 0, 0, 1, 8'h18, e[3:0], "R10 R11 R7 events with write");
         idle("R12 hold after event");
      end

      // R1 mid-run power-on reset
      step(0, 0, 0, 0, 1, 8'h07, 4'b0100, "R7 preset before reset");
      @(negedge clk);
      rst_n = 0;
      #1;
      model_por();
      check("R1 asynchronous reset", 8'h18);
      @(negedge clk);
      rst_n = 1;
      idle("R1 after second reset");

      finish_run();
   end

endmodule